// File: doc/BRIEF.md
# Audio Sample FIFO with Level Status and Event Routing

This block is a first-in, first-out sample buffer that sits between a bus-side data port and a serial audio engine. It holds 32 words of 32 bits by default. A parameter fixes its direction. In transmit form, the bus fills the buffer and the engine drains it. In receive form, the engine fills it and the bus drains it. The write and read positions are exposed as counters that carry one extra wrap bit, so software can tell a full buffer from an empty one by comparing the two.

Both data sides are valid/ready streams, and the rules are the usual ones:
- A word moves on a clock edge where valid and ready are both high.
- The write side lowers `wr_ready` while 32 words are held.
- The read side lowers `rd_valid` while the buffer is empty.
- A producer may hold valid high during back-pressure without losing anything, except in the one case below.

The block's own engine side does not wait. A transmit engine that asks for a sample from an empty buffer, or a receive engine that offers a sample to a full one, records a sticky error.

The status section derives the following:
- a level flag from a programmable threshold;
- a boundary flag, which is empty for transmit and full for receive;
- three sticky event flags: error, sync error and word start. Software clears these by writing 1.

Separate enables route every flag to one interrupt line. The two level flags can also be routed to one DMA request line. A flush pulse returns both position counters to zero.

Top module: `audio_wm_fifo`

## Requirements
- R1: After reset both position counters are 0, the buffer is empty (`rd_valid`=0, `wr_ready`=1), and the error, sync and word flags are 0.
- R2: Words leave in the order they were accepted. Each counter advances by one per accepted word, modulo 64. Bit 5 is the wrap bit, and the fill level is `wr_ptr - rd_ptr` modulo 64.
- R3: `req_flag` is 1 when the fill level is less than or equal to `watermark` in transmit form. In receive form it is 1 when the fill level is greater than `watermark`.
- R4: `warn_flag` means empty in transmit form and 32 words held in receive form. `wr_ready` is 0 exactly when 32 words are held, and `rd_valid` is 0 exactly when the buffer is empty.
- R5: `err_flag` is set on the edge after a missed transfer. In transmit form this is `rd_ready`=1 while empty, which pops nothing. In receive form it is `wr_valid`=1 while full, and the word is dropped. The flag then stays set until cleared.
- R6: A pulse on `sync_err_evt` sets `sync_flag`, and a pulse on `word_start_evt` sets `word_flag`. Both stay set until cleared.
- R7: `flag_clr` clears sticky flags where its bit is 1: bit 0 clears error, bit 1 clears sync, bit 2 clears word. A 0 bit leaves its flag unchanged. A set and a clear on the same edge leave the flag set.
- R8: `fifo_rst` sets both counters to 0 on the next edge and leaves the sticky flags untouched. A push or pop in that same cycle has no effect.
- R9: `irq` is the OR of the flags whose `irq_en` bit is 1: bit 0 request, bit 1 warning, bit 2 error, bit 3 sync, bit 4 word.
- R10: `dma_req` is (`dma_en[0]` AND `req_flag`) OR (`dma_en[1]` AND `warn_flag`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_rst | input | 1 | Flush pulse, clears both counters |
| wr_valid | input | 1 | Write side: word offered |
| wr_ready | output | 1 | Write side: space available |
| wr_data | input | DATA_W | Write side: word |
| rd_valid | output | 1 | Read side: word available |
| rd_ready | input | 1 | Read side: word taken / engine demand |
| rd_data | output | DATA_W | Read side: head word |
| watermark | input | WM_W | Threshold for the request flag |
| sync_err_evt | input | 1 | Engine frame-sync error pulse |
| word_start_evt | input | 1 | Engine word-start pulse |
| flag_clr | input | 3 | Write-1-to-clear for error, sync, word |
| irq_en | input | 5 | Interrupt enables per flag |
| dma_en | input | 2 | DMA enables for request and warning |
| wr_ptr | output | PTR_W | Write position with wrap bit |
| rd_ptr | output | PTR_W | Read position with wrap bit |
| req_flag | output | 1 | Threshold reached |
| warn_flag | output | 1 | Empty (transmit) / full (receive) |
| err_flag | output | 1 | Sticky underrun / overflow |
| sync_flag | output | 1 | Sticky sync error |
| word_flag | output | 1 | Sticky word start |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The assertions check several properties on every cycle:
- the fill level never exceeds the depth;
- the write counter moves only by accepted words;
- back-pressure is present at full and empty;
- a missed engine transfer always sets the error flag, and the flag holds without a clear;
- a sync pulse sets its flag;
- a flush zeroes both counters;
- an enabled error raises the interrupt.

Other behaviour needs the bench's scenarios. These cover data order across a counter wrap, the exact threshold boundary in both directions, a dropped overflow word, set-over-clear priority, and the effect of each routing enable, on a transmit and a receive instance fed the same stimulus.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  // flag vector positions used by the routing stage
  localparam int FL_REQ  = 0;
  localparam int FL_WARN = 1;
  localparam int FL_ERR  = 2;
  localparam int FL_SYNC = 3;
  localparam int FL_WORD = 4;
  localparam int NUM_FLAGS = 5;
  // sticky flag positions, matching flag_clr bits
  localparam int ST_ERR  = 0;
  localparam int ST_SYNC = 1;
  localparam int ST_WORD = 2;
  localparam int NUM_STICKY = 3;
  // level flags that may raise a DMA request
  localparam int NUM_DMA = 2;
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PW-1:0]     wr_ptr,
  output logic [PW-1:0]     rd_ptr,
  output logic [PW-1:0]     fill
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rdata = mem[rd_ptr[AW-1:0]];
  assign fill  = wr_ptr - rd_ptr;
endmodule

// File: rtl/afifo_level.sv
module afifo_level #(
  parameter bit IS_TX = 1'b1,
  parameter int DEPTH = 32,
  parameter int PW    = 6,
  parameter int WM_W  = 5,
  localparam int CW = (PW > WM_W) ? PW : WM_W
) (
  input  logic [PW-1:0]   fill,
  input  logic [WM_W-1:0] watermark,
  output logic            req,
  output logic            warn
);
  logic [CW-1:0] fill_x, wm_x;
  assign fill_x = CW'(fill);
  assign wm_x   = CW'(watermark);

  generate
    if (IS_TX) begin : g_tx
      // bus must refill while level is low
      assign req  = (fill_x <= wm_x);
      assign warn = (fill == '0);
    end else begin : g_rx
      // bus must drain while level is high
      assign req  = (fill_x > wm_x);
      assign warn = (fill == PW'(DEPTH));
    end
  endgenerate
endmodule

// File: rtl/afifo_sticky.sv
module afifo_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q[i] <= 1'b0;
        else if (set[i]) q[i] <= 1'b1;   // a new event outranks a clear
        else if (clr[i]) q[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/afifo_route.sv
module afifo_route #(
  parameter int NF = 5,
  parameter int ND = 2
) (
  input  logic [NF-1:0] flags,
  input  logic [NF-1:0] irq_en,
  input  logic [ND-1:0] dma_en,
  output logic          irq,
  output logic          dma_req
);
  assign irq     = |(flags & irq_en);
  assign dma_req = |(flags[ND-1:0] & dma_en);
endmodule

// File: rtl/audio_wm_fifo.sv
module audio_wm_fifo
  import afifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int WM_W   = 5,
  parameter bit IS_TX  = 1'b1,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic [WM_W-1:0]   watermark,
  input  logic              sync_err_evt,
  input  logic              word_start_evt,
  input  logic [2:0]        flag_clr,
  input  logic [4:0]        irq_en,
  input  logic [1:0]        dma_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              req_flag,
  output logic              warn_flag,
  output logic              err_flag,
  output logic              sync_flag,
  output logic              word_flag,
  output logic              irq,
  output logic              dma_req
);
  logic [PTR_W-1:0]      fill;
  logic                  push, pop, miss;
  logic [NUM_STICKY-1:0] st_set, st_q;
  logic [NUM_FLAGS-1:0]  flags;

  assign wr_ready = (fill != PTR_W'(DEPTH));
  assign rd_valid = (fill != '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_valid && rd_ready;

  afifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(fifo_rst), .push(push), .pop(pop),
    .wdata(wr_data), .rdata(rd_data), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .fill(fill)
  );

  afifo_level #(.IS_TX(IS_TX), .DEPTH(DEPTH), .PW(PTR_W), .WM_W(WM_W)) u_level (
    .fill(fill), .watermark(watermark), .req(req_flag), .warn(warn_flag)
  );

  // engine-side missed transfer: the engine never waits
  generate
    if (IS_TX) begin : g_miss_tx
      assign miss = rd_ready && !rd_valid;
    end else begin : g_miss_rx
      assign miss = wr_valid && !wr_ready;
    end
  endgenerate

  always_comb begin
    st_set          = '0;
    st_set[ST_ERR]  = miss;
    st_set[ST_SYNC] = sync_err_evt;
    st_set[ST_WORD] = word_start_evt;
  end

  afifo_sticky #(.N(NUM_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr(flag_clr), .q(st_q)
  );

  assign err_flag  = st_q[ST_ERR];
  assign sync_flag = st_q[ST_SYNC];
  assign word_flag = st_q[ST_WORD];

  always_comb begin
    flags          = '0;
    flags[FL_REQ]  = req_flag;
    flags[FL_WARN] = warn_flag;
    flags[FL_ERR]  = err_flag;
    flags[FL_SYNC] = sync_flag;
    flags[FL_WORD] = word_flag;
  end

  afifo_route #(.NF(NUM_FLAGS), .ND(NUM_DMA)) u_route (
    .flags(flags), .irq_en(irq_en), .dma_en(dma_en), .irq(irq), .dma_req(dma_req)
  );
endmodule

// File: rtl/afifo_checker.sv
module afifo_checker #(
  parameter bit IS_TX = 1'b1,
  parameter int DEPTH = 32,
  parameter int PW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_rst,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          err_clr,
  input logic          err_flag,
  input logic          sync_err_evt,
  input logic          sync_flag,
  input logic          err_irq_en,
  input logic          irq,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr
);
  logic [PW-1:0] lvl;
  logic          took, missed;
  assign lvl    = wr_ptr - rd_ptr;
  assign took   = wr_valid && wr_ready;
  assign missed = IS_TX ? (rd_ready && !rd_valid) : (wr_valid && !wr_ready);

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= PW'(DEPTH));
  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_rst |=> wr_ptr == $past(wr_ptr) + {{(PW-1){1'b0}}, $past(took)});
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == PW'(DEPTH)) |-> !wr_ready);
  assert_no_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == rd_ptr) |-> !rd_valid);
  assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> err_flag);
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
  assert_sync_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_evt |=> sync_flag);
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> (wr_ptr == '0 && rd_ptr == '0));
  assert_irq_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq_en && err_flag) |-> irq);
endmodule

bind audio_wm_fifo afifo_checker #(.IS_TX(IS_TX), .DEPTH(DEPTH), .PW(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_rst(fifo_rst), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .err_clr(flag_clr[0]), .err_flag(err_flag), .sync_err_evt(sync_err_evt),
  .sync_flag(sync_flag), .err_irq_en(irq_en[2]), .irq(irq),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/test_audio_wm_fifo.sv
`timescale 1ns/1ps
module test_audio_wm_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_rst = 1'b0, wr_valid = 1'b0, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0]  watermark = 5'd4;
  logic        sync_evt = 1'b0, word_evt = 1'b0;
  logic [2:0]  flag_clr = '0;
  logic [4:0]  irq_en = '0;
  logic [1:0]  dma_en = '0;

  logic        t_wrdy, t_rval, t_req, t_warn, t_err, t_sync, t_word, t_irq, t_dma;
  logic        r_wrdy, r_rval, r_req, r_warn, r_err, r_sync, r_word, r_irq, r_dma;
  logic [31:0] t_rdata, r_rdata;
  logic [5:0]  t_wp, t_rp, r_wp, r_rp;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [31:0] q[$];
  int wp = 0, rp = 0;

  always #4 clk = ~clk;

  audio_wm_fifo #(.IS_TX(1'b1)) i_audio_wm_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_rst(fifo_rst), .wr_valid(wr_valid),
    .wr_ready(t_wrdy), .wr_data(wr_data), .rd_valid(t_rval), .rd_ready(rd_ready),
    .rd_data(t_rdata), .watermark(watermark), .sync_err_evt(sync_evt),
    .word_start_evt(word_evt), .flag_clr(flag_clr), .irq_en(irq_en), .dma_en(dma_en),
    .wr_ptr(t_wp), .rd_ptr(t_rp), .req_flag(t_req), .warn_flag(t_warn),
    .err_flag(t_err), .sync_flag(t_sync), .word_flag(t_word), .irq(t_irq), .dma_req(t_dma)
  );

  audio_wm_fifo #(.IS_TX(1'b0)) i_audio_wm_fifo_rx (
    .clk(clk), .rst_n(rst_n), .fifo_rst(fifo_rst), .wr_valid(wr_valid),
    .wr_ready(r_wrdy), .wr_data(wr_data), .rd_valid(r_rval), .rd_ready(rd_ready),
    .rd_data(r_rdata), .watermark(watermark), .sync_err_evt(sync_evt),
    .word_start_evt(word_evt), .flag_clr(flag_clr), .irq_en(irq_en), .dma_en(dma_en),
    .wr_ptr(r_wp), .rd_ptr(r_rp), .req_flag(r_req), .warn_flag(r_warn),
    .err_flag(r_err), .sync_flag(r_sync), .word_flag(r_word), .irq(r_irq), .dma_req(r_dma)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_push(input logic [31:0] d);
    wr_valid = 1'b1; wr_data = d;
    cyc();
    wr_valid = 1'b0;
    if (q.size() < 32) begin q.push_back(d); wp = (wp + 1) % 64; end
  endtask

  task automatic do_pop(input string tag);
    logic [31:0] e;
    e = q.pop_front();
    chk({tag, " tx head"}, t_rdata, e);
    chk({tag, " rx head"}, r_rdata, e);
    rd_ready = 1'b1;
    cyc();
    rd_ready = 1'b0;
    rp = (rp + 1) % 64;
  endtask

  task automatic t_reset();
    chk("R1 tx wr_ptr", t_wp, 0);           chk("R1 rx rd_ptr", r_rp, 0);
    chk("R1 tx rd_valid", t_rval, 0);       chk("R1 rx wr_ready", r_wrdy, 1);
    chk("R1 sticky tx", {t_err, t_sync, t_word}, 0);
    chk("R1 sticky rx", {r_err, r_sync, r_word}, 0);
    chk("R3 tx req empty wm4", t_req, 1);   chk("R3 rx req empty wm4", r_req, 0);
    chk("R4 tx warn empty", t_warn, 1);     chk("R4 rx warn empty", r_warn, 0);
  endtask

  task automatic t_watermark();
    watermark = 5'd0; cyc();
    chk("R3 tx req 0<=0", t_req, 1);        chk("R3 rx req 0>0", r_req, 0);
    do_push(32'h100);
    chk("R3 tx req 1<=0", t_req, 0);        chk("R3 rx req 1>0", r_req, 1);
    watermark = 5'd4;
    for (int i = 1; i < 4; i++) do_push(32'h100 + i);
    chk("R3 tx req 4<=4", t_req, 1);        chk("R3 rx req 4>4", r_req, 0);
    do_push(32'h104);
    chk("R3 tx req 5<=4", t_req, 0);        chk("R3 rx req 5>4", r_req, 1);
    chk("R2 wr_ptr after 5", t_wp, 5);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) do_pop("R2 order");
    chk("R2 rd_ptr after 5", t_rp, 5);      chk("R4 rx rd_valid empty", r_rval, 0);
  endtask

  task automatic t_full_overflow();
    for (int i = 0; i < 32; i++) do_push(32'hA000_0000 + i * 32'h0101);
    chk("R2 wr_ptr 37", t_wp, 37);
    chk("R4 wr_ready full", {t_wrdy, r_wrdy}, 2'b00);
    chk("R4 rx warn full", r_warn, 1);      chk("R4 tx warn full", t_warn, 0);
    do_push(32'hDEAD_BEEF);
    chk("R5 rx overflow err", r_err, 1);    chk("R5 tx no err on bus overflow", t_err, 0);
    chk("R5 dropped word wr_ptr", r_wp, 37);
    for (int i = 0; i < 32; i++) do_pop("R5 drain");
    chk("R4 tx warn drained", t_warn, 1);   chk("R2 rd_ptr 37", t_rp, 37);
    rd_ready = 1'b1; cyc(); rd_ready = 1'b0;
    chk("R5 tx underrun err", t_err, 1);    chk("R5 underrun no pop", t_rp, 37);
    cyc();
    chk("R5 sticky held", {t_err, r_err}, 2'b11);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 30; i++) do_push(32'h5500 + i);
    chk("R2 wrap wr_ptr", t_wp, 6'((37 + 30) % 64));
    chk("R3 rx req 30>4", r_req, 1);
    for (int i = 0; i < 30; i++) do_pop("R2 wrap order");
    chk("R2 wrap rd_ptr", r_rp, 3);
  endtask

  task automatic t_w1c();
    flag_clr = 3'b000; cyc();
    chk("R7 zero keeps err", {t_err, r_err}, 2'b11);
    flag_clr = 3'b010; cyc();
    chk("R7 other bit keeps err", {t_err, r_err}, 2'b11);
    flag_clr = 3'b001; cyc(); flag_clr = 3'b000;
    chk("R7 w1c err", {t_err, r_err}, 2'b00);
    flag_clr = 3'b001; rd_ready = 1'b1; cyc(); flag_clr = 3'b000; rd_ready = 1'b0;
    chk("R7 set beats clear", {t_err, r_err}, 2'b10);
  endtask

  task automatic t_events();
    sync_evt = 1'b1; cyc(); sync_evt = 1'b0;
    chk("R6 sync set", {t_sync, r_sync, t_word}, 3'b110);
    word_evt = 1'b1; cyc(); word_evt = 1'b0;
    chk("R6 word set", {t_word, r_word}, 2'b11);
    flag_clr = 3'b110; cyc(); flag_clr = 3'b000;
    chk("R7 clear sync word", {t_sync, r_sync, t_word, r_word}, 4'b0000);
    chk("R7 err untouched", t_err, 1);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 3; i++) do_push(32'h77 + i);
    fifo_rst = 1'b1; wr_valid = 1'b1; wr_data = 32'h999; cyc();
    fifo_rst = 1'b0; wr_valid = 1'b0;
    q.delete(); wp = 0; rp = 0;
    chk("R8 flush ptrs", {t_wp, t_rp, r_wp, r_rp}, 24'h0);
    chk("R8 flush empty", {t_rval, r_rval}, 2'b00);
    chk("R8 sticky kept", t_err, 1);
    flag_clr = 3'b001; cyc(); flag_clr = 3'b000;
    chk("R7 err cleared", t_err, 0);
  endtask

  task automatic t_routing();
    chk("R9 no enable no irq", {t_irq, r_irq}, 2'b00);
    irq_en = 5'b00001; cyc();
    chk("R9 req enable", {t_irq, r_irq}, 2'b10);
    irq_en = 5'b00010; cyc();
    chk("R9 warn enable", {t_irq, r_irq}, 2'b10);
    irq_en = 5'b11100; cyc();
    chk("R9 clear flags masked", {t_irq, r_irq}, 2'b00);
    sync_evt = 1'b1; cyc(); sync_evt = 1'b0;
    chk("R9 sync raises irq", {t_irq, r_irq}, 2'b11);
    irq_en = 5'b10000; cyc();
    chk("R9 word enable only", {t_irq, r_irq}, 2'b00);
    irq_en = 5'b00000; flag_clr = 3'b010; cyc(); flag_clr = 3'b000;
    dma_en = 2'b01; cyc();
    chk("R10 dma req empty", {t_dma, r_dma}, 2'b10);
    dma_en = 2'b10; cyc();
    chk("R10 dma warn empty", {t_dma, r_dma}, 2'b10);
    for (int i = 0; i < 32; i++) do_push(32'hC0 + i);
    chk("R10 dma warn full", {t_dma, r_dma}, 2'b01);
    dma_en = 2'b01; cyc();
    chk("R10 dma req full", {t_dma, r_dma}, 2'b01);
    dma_en = 2'b00; cyc();
    chk("R10 dma disabled", {t_dma, r_dma}, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_watermark();
    t_order();
    t_full_overflow();
    t_wrap();
    t_w1c();
    t_events();
    t_flush();
    t_routing();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule